// File: doc/BRIEF.md
# Write Protection Controller for a Two-Wire Serial Memory

This block sits beside the byte engine of a two-wire serial memory slave and decides, for every received byte, whether the slave acknowledges it and whether a data byte may be committed to the array. The engine reports each byte with its phase: device select, word address or data. With each data byte it also gives the target word address. The block reports its decision one clock later.

Write protection comes from three sources. The first is a write-protect input level that blocks the whole array. The second is a reversible software flag. The third is a permanent software flag. Both software flags guard only the lower part of the address space. Protect commands reuse the byte-write format under a separate device code, and their address and data bytes are ignored. The reversible set and clear commands are qualified by a high-voltage indication on one strap. The permanent set command compares the slave bits with the straps in the usual way. The same codes with the read bit set act as status queries.

`rst_ni` models the power-on clear. Start and stop conditions only end the current command. They never clear a flag.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset `ack_vld_o`, `ack_o` and `commit_o` are 0, and with `wp_i` low `wr_mask_o` is all ones (bit r covers region r, where region r is the address range whose top REG_BITS bits equal r).
- R2: Every cycle with `byte_vld_i` high is followed in the next cycle by `ack_vld_o` high, and in no other cycle. `ack_o` and `commit_o` are 0 whenever `ack_vld_o` is 0, and `commit_o` implies `ack_o`.
- R3: A device-select byte (phase 2'b00) equal to {4'b1010, strap_i, rw}, where rw is bit 0, is acknowledged for either value of rw. A byte with different slave bits is not acknowledged.
- R4: While `wp_i` is high, no data byte (phase 2'b10) is acknowledged or committed, `wr_mask_o` is all zeros, and protect write commands are not acknowledged.
- R5: A data byte whose address is below SW_LIMIT (default 8'h80) is refused while either software flag is set. A data byte at or above SW_LIMIT is acknowledged and committed when `wp_i` is low.
- R6: Device select 8'b0110_001_0 with `hv_i` high, followed by a word-address byte (phase 2'b01), a data byte and a stop, sets the reversible flag. All three bytes are acknowledged.
- R7: The same sequence with device select 8'b0110_011_0 and `hv_i` high clears the reversible flag.
- R8: Device select {4'b0110, strap_i, 1'b0}, followed by two bytes and a stop, sets the permanent flag. From then on no protect command or query is acknowledged. The lower region stays unwritable whatever `wp_i` is, and no start or stop clears the flag.
- R9: A flag changes only on a stop that follows exactly three acknowledged bytes of one protect command. A stop after fewer bytes, or a start before the stop, leaves both flags unchanged.
- R10: A query with rw=1 (8'b0110_001_1 or 8'b0110_011_1 with `hv_i` high) is acknowledged only when neither flag is set. A query {4'b0110, strap_i, 1'b1} is acknowledged only when the permanent flag is clear. `wp_i` does not affect queries.
- R11: The word-address byte of a memory write is acknowledged. An address or data byte outside an acknowledged command is not. A fourth byte in a protect command is not acknowledged and cancels that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on clear |
| start_i | input | 1 | Start condition seen (pulse) |
| stop_i | input | 1 | Stop condition seen (pulse) |
| byte_vld_i | input | 1 | A received byte is presented |
| phase_i | input | 2 | Byte phase: 00 device select, 01 word address, 10 data |
| byte_i | input | 8 | Received byte |
| waddr_i | input | ADDR_W | Target word address of a data byte |
| strap_i | input | 3 | Slave address straps |
| wp_i | input | 1 | Write-protect level |
| hv_i | input | 1 | High-voltage qualifier on the lowest strap |
| ack_vld_o | output | 1 | Decision valid for the previous byte |
| ack_o | output | 1 | Acknowledge the byte |
| commit_o | output | 1 | Commit the data byte to the array |
| wr_mask_o | output | 2**REG_BITS | Per-region write-allowed mask |

## Verification
The assertions check on every cycle that each decision is paired with its byte and that commit always comes with acknowledge. They also check that nothing is committed while the protect level is high or into a locked region, that the permanent flag never falls and keeps the lower region closed, and that flags move only on a stop. The scenarios check what a single cycle cannot: the full three-byte-plus-stop sequence that sets or clears a flag, cancellation by a short or long command, query answers for each flag state, and the lockout of all protect traffic after the permanent set.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam logic [1:0] PH_DEV  = 2'b00;
  localparam logic [1:0] PH_ADDR = 2'b01;
  localparam logic [1:0] PH_DATA = 2'b10;

  localparam logic [3:0] MEM_CODE  = 4'b1010;
  localparam logic [3:0] PROT_CODE = 4'b0110;
  localparam logic [2:0] SET_R_SEL = 3'b001;
  localparam logic [2:0] CLR_R_SEL = 3'b011;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MEM_WR,
    CMD_MEM_RD,
    CMD_SET_R,
    CMD_CLR_R,
    CMD_SET_P,
    CMD_QRY_R,
    CMD_QRY_P
  } cmd_e;

  function automatic logic is_prot_wr(cmd_e c);
    return (c == CMD_SET_R) || (c == CMD_CLR_R) || (c == CMD_SET_P);
  endfunction

  function automatic logic is_prot_any(cmd_e c);
    return is_prot_wr(c) || (c == CMD_QRY_R) || (c == CMD_QRY_P);
  endfunction
endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
  import wprot_pkg::*;
(
  input  logic [7:0] sel_i,
  input  logic [2:0] strap_i,
  input  logic       hv_i,
  output cmd_e       cmd_o
);
  logic [3:0] code;
  logic [2:0] slv;
  logic       rd;

  assign code = sel_i[7:4];
  assign slv  = sel_i[3:1];
  assign rd   = sel_i[0];

  always_comb begin
    cmd_o = CMD_NONE;
    if (code == MEM_CODE) begin
      if (slv == strap_i) cmd_o = rd ? CMD_MEM_RD : CMD_MEM_WR;
    end else if (code == PROT_CODE) begin
      // high-voltage qualified codes take priority over the strap compare
      if (hv_i && slv == SET_R_SEL)      cmd_o = rd ? CMD_QRY_R : CMD_SET_R;
      else if (hv_i && slv == CLR_R_SEL) cmd_o = rd ? CMD_QRY_R : CMD_CLR_R;
      else if (slv == strap_i)           cmd_o = rd ? CMD_QRY_P : CMD_SET_P;
    end
  end
endmodule

// File: rtl/wprot_region.sv
module wprot_region #(
  parameter int ADDR_W   = 8,
  parameter int REG_BITS = 1,
  parameter int SW_LIMIT = 128
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wp_i,
  input  logic                     lock_i,
  output logic [(1<<REG_BITS)-1:0] mask_o,
  output logic                     addr_ok_o
);
  localparam int NREG     = 1 << REG_BITS;
  localparam int REG_SIZE = 1 << (ADDR_W - REG_BITS);
  localparam logic [ADDR_W:0] LIM = SW_LIMIT[ADDR_W:0];

  logic in_sw;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int  BASE = r * REG_SIZE;
    localparam bit  SWZ  = (BASE < SW_LIMIT);
    assign mask_o[r] = ~wp_i & ~(SWZ & lock_i);
  end

  assign in_sw     = ({1'b0, addr_i} < LIM);
  assign addr_ok_o = ~wp_i & ~(in_sw & lock_i);
endmodule

// File: rtl/wprot_flags.sv
module wprot_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_r_i,
  input  logic clr_r_i,
  input  logic set_p_i,
  output logic rswp_o,
  output logic pswp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rswp_o <= 1'b0;
      pswp_o <= 1'b0;
    end else begin
      if (set_r_i)      rswp_o <= 1'b1;
      else if (clr_r_i) rswp_o <= 1'b0;
      // permanent: no path back to 0 except power-on clear
      if (set_p_i)      pswp_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_BITS = 1,
  parameter int SW_LIMIT = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     byte_vld_i,
  input  logic [1:0]               phase_i,
  input  logic [7:0]               byte_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [2:0]               strap_i,
  input  logic                     wp_i,
  input  logic                     hv_i,
  output logic                     ack_vld_o,
  output logic                     ack_o,
  output logic                     commit_o,
  output logic [(1<<REG_BITS)-1:0] wr_mask_o
);
  localparam int NREG = 1 << REG_BITS;

  cmd_e       dec_cmd, sess_q, sess_d;
  logic [1:0] cnt_q, cnt_d;
  logic       ack_d, commit_d, addr_ok;
  logic       rswp_q, pswp_q;
  logic       set_r, clr_r, set_p;

  wprot_decode u_dec (
    .sel_i  (byte_i),
    .strap_i(strap_i),
    .hv_i   (hv_i),
    .cmd_o  (dec_cmd)
  );

  wprot_region #(
    .ADDR_W  (ADDR_W),
    .REG_BITS(REG_BITS),
    .SW_LIMIT(SW_LIMIT)
  ) u_region (
    .addr_i   (waddr_i),
    .wp_i     (wp_i),
    .lock_i   (rswp_q | pswp_q),
    .mask_o   (wr_mask_o),
    .addr_ok_o(addr_ok)
  );

  wprot_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_r_i(set_r),
    .clr_r_i(clr_r),
    .set_p_i(set_p),
    .rswp_o (rswp_q),
    .pswp_o (pswp_q)
  );

  always_comb begin
    sess_d   = sess_q;
    cnt_d    = cnt_q;
    ack_d    = 1'b0;
    commit_d = 1'b0;
    set_r    = 1'b0;
    clr_r    = 1'b0;
    set_p    = 1'b0;
    if (start_i) begin
      sess_d = CMD_NONE;
      cnt_d  = 2'd0;
    end else if (stop_i) begin
      if (cnt_q == 2'd3) begin
        set_r = (sess_q == CMD_SET_R);
        clr_r = (sess_q == CMD_CLR_R);
        set_p = (sess_q == CMD_SET_P);
      end
      sess_d = CMD_NONE;
      cnt_d  = 2'd0;
    end else if (byte_vld_i) begin
      case (phase_i)
        PH_DEV: begin
          case (dec_cmd)
            CMD_MEM_WR, CMD_MEM_RD:         ack_d = 1'b1;
            CMD_SET_R, CMD_CLR_R, CMD_SET_P: ack_d = ~wp_i & ~pswp_q;
            CMD_QRY_R:                       ack_d = ~pswp_q & ~rswp_q;
            CMD_QRY_P:                       ack_d = ~pswp_q;
            default:                         ack_d = 1'b0;
          endcase
          sess_d = ack_d ? dec_cmd : CMD_NONE;
          cnt_d  = ack_d ? 2'd1 : 2'd0;
        end
        PH_ADDR: begin
          if (sess_q == CMD_MEM_WR) begin
            ack_d = 1'b1;
          end else if (is_prot_wr(sess_q) && cnt_q == 2'd1) begin
            ack_d = 1'b1;
            cnt_d = 2'd2;
          end else if (is_prot_wr(sess_q)) begin
            sess_d = CMD_NONE;
            cnt_d  = 2'd0;
          end
        end
        PH_DATA: begin
          if (sess_q == CMD_MEM_WR) begin
            ack_d    = addr_ok;
            commit_d = addr_ok;
          end else if (is_prot_wr(sess_q) && cnt_q == 2'd2) begin
            ack_d = 1'b1;
            cnt_d = 2'd3;
          end else if (is_prot_wr(sess_q)) begin
            // over-long protect command is cancelled
            sess_d = CMD_NONE;
            cnt_d  = 2'd0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q    <= CMD_NONE;
      cnt_q     <= 2'd0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      sess_q    <= sess_d;
      cnt_q     <= cnt_d;
      ack_vld_o <= byte_vld_i;
      ack_o     <= ack_d;
      commit_o  <= commit_d;
    end
  end

  logic unused_nreg;
  assign unused_nreg = (NREG == 0);
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NREG     = 2,
  parameter int SW_LIMIT = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              byte_vld_i,
  input logic [1:0]        phase_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic              wp_i,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic              commit_o,
  input logic [NREG-1:0]   wr_mask_o,
  input cmd_e              dec_cmd,
  input logic              rswp_q,
  input logic              pswp_q
);
  localparam logic [ADDR_W:0] LIM = SW_LIMIT[ADDR_W:0];

  assert_ack_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> ack_vld_o);
  assert_ack_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !ack_vld_o);
  assert_ack_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_vld_o |-> (!ack_o && !commit_o));
  assert_commit_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ack_o);
  assert_wp_no_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_i) |-> !commit_o);
  assert_lock_no_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && $past(rswp_q | pswp_q)) |-> ({1'b0, $past(waddr_i)} >= LIM));
  assert_perm_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pswp_q) |-> pswp_q);
  assert_perm_locks_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pswp_q |-> !wr_mask_o[0]);
  assert_perm_no_prot_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && $past(pswp_q) && $past(phase_i == PH_DEV) && $past(is_prot_any(dec_cmd)))
      |-> !ack_o);
  assert_flags_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stop_i) |-> (rswp_q == $past(rswp_q) && pswp_q == $past(pswp_q)));
endmodule

bind wprot_ctrl wprot_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .NREG    (NREG),
  .SW_LIMIT(SW_LIMIT)
) u_chk (.*);

// File: tb/wprot_ctrl_test.sv
module wprot_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [1:0] phase_i = 2'b00;
  logic [7:0] byte_i = 8'h00, waddr_i = 8'h00;
  logic [2:0] strap_i = 3'b101;
  logic       wp_i = 1'b0, hv_i = 1'b0;
  logic       ack_vld_o, ack_o, commit_o;
  logic [1:0] wr_mask_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wprot_ctrl uut (.*);

  // strap 101: memory write AA, read AB; permanent set 6A, query 6B
  localparam logic [7:0] MEM_WR = 8'hAA, MEM_RD = 8'hAB, MEM_BAD = 8'hA8;
  localparam logic [7:0] SET_R = 8'h62, CLR_R = 8'h66, SET_P = 8'h6A;
  localparam logic [7:0] QRY_R = 8'h63, QRY_P = 8'h6B;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] ph, logic [7:0] b, logic [7:0] a,
                      logic exp_ack, logic exp_com, string tag);
    @(negedge clk_i);
    byte_vld_i = 1'b1; phase_i = ph; byte_i = b; waddr_i = a;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    check({tag, " vld"}, {7'd0, ack_vld_o}, 8'd1);
    check({tag, " ack"}, {7'd0, ack_o}, {7'd0, exp_ack});
    check({tag, " commit"}, {7'd0, commit_o}, {7'd0, exp_com});
  endtask

  task automatic bus_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic bus_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  task automatic prot_cmd(logic [7:0] dev, logic exp_ack, string tag);
    bus_start();
    send(2'b00, dev, 8'h00, exp_ack, 1'b0, tag);
    send(2'b01, 8'h5A, 8'h00, exp_ack, 1'b0, tag);
    send(2'b10, 8'hC3, 8'h00, exp_ack, 1'b0, tag);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 ack_vld", {7'd0, ack_vld_o}, 8'd0);
    check("R1 ack", {7'd0, ack_o}, 8'd0);
    check("R1 commit", {7'd0, commit_o}, 8'd0);
    check("R1 mask", {6'd0, wr_mask_o}, 8'h03);
  endtask

  task automatic t_memory();
    bus_start();
    send(2'b00, MEM_WR, 8'h00, 1'b1, 1'b0, "R3 dev match");
    send(2'b01, 8'h10, 8'h00, 1'b1, 1'b0, "R11 word addr");
    send(2'b10, 8'h11, 8'h10, 1'b1, 1'b1, "R5 low free");
    send(2'b10, 8'h22, 8'h90, 1'b1, 1'b1, "R5 high free");
    bus_stop();
    bus_start();
    send(2'b00, MEM_BAD, 8'h00, 1'b0, 1'b0, "R3 dev mismatch");
    send(2'b10, 8'h33, 8'h10, 1'b0, 1'b0, "R11 data no session");
    bus_start();
    send(2'b00, MEM_RD, 8'h00, 1'b1, 1'b0, "R3 read dev");
    bus_stop();
  endtask

  task automatic t_wp();
    wp_i = 1'b1;
    @(negedge clk_i);
    check("R4 mask", {6'd0, wr_mask_o}, 8'h00);
    bus_start();
    send(2'b00, MEM_WR, 8'h00, 1'b1, 1'b0, "R4 dev");
    send(2'b01, 8'h90, 8'h00, 1'b1, 1'b0, "R4 addr");
    send(2'b10, 8'h44, 8'h90, 1'b0, 1'b0, "R4 data high");
    bus_stop();
    prot_cmd(SET_R, 1'b0, "R4 set refused");
    check("R4 flag kept", {6'd0, wr_mask_o}, 8'h00);
    hv_i = 1'b1;
    bus_start();
    send(2'b00, QRY_R, 8'h00, 1'b1, 1'b0, "R10 query under wp");
    bus_stop();
    wp_i = 1'b0;
    @(negedge clk_i);
    check("R4 no flag set", {6'd0, wr_mask_o}, 8'h03);
  endtask

  task automatic t_partial();
    hv_i = 1'b1;
    bus_start();
    send(2'b00, SET_R, 8'h00, 1'b1, 1'b0, "R9 short dev");
    send(2'b01, 8'h00, 8'h00, 1'b1, 1'b0, "R9 short addr");
    bus_stop();
    check("R9 short stop", {6'd0, wr_mask_o}, 8'h03);
    bus_start();
    send(2'b00, SET_R, 8'h00, 1'b1, 1'b0, "R9 restart dev");
    send(2'b01, 8'h00, 8'h00, 1'b1, 1'b0, "R9 restart addr");
    send(2'b10, 8'h00, 8'h00, 1'b1, 1'b0, "R9 restart data");
    check("R9 before stop", {6'd0, wr_mask_o}, 8'h03);
    bus_start();
    bus_stop();
    check("R9 start aborts", {6'd0, wr_mask_o}, 8'h03);
  endtask

  task automatic t_reversible();
    hv_i = 1'b1;
    prot_cmd(SET_R, 1'b1, "R6 set");
    check("R6 low locked", {6'd0, wr_mask_o}, 8'h02);
    bus_start();
    send(2'b00, MEM_WR, 8'h00, 1'b1, 1'b0, "R5 dev");
    send(2'b01, 8'h20, 8'h00, 1'b1, 1'b0, "R5 addr");
    send(2'b10, 8'h55, 8'h7F, 1'b0, 1'b0, "R5 low refused");
    send(2'b10, 8'h66, 8'h80, 1'b1, 1'b1, "R5 high open");
    bus_stop();
    bus_start();
    send(2'b00, QRY_R, 8'h00, 1'b0, 1'b0, "R10 query r set");
    bus_start();
    send(2'b00, QRY_P, 8'h00, 1'b1, 1'b0, "R10 query p clear");
    bus_stop();
    // four-byte clear: fourth byte refused, command cancelled
    bus_start();
    send(2'b00, CLR_R, 8'h00, 1'b1, 1'b0, "R11 long dev");
    send(2'b01, 8'h00, 8'h00, 1'b1, 1'b0, "R11 long addr");
    send(2'b10, 8'h00, 8'h00, 1'b1, 1'b0, "R11 long data");
    send(2'b10, 8'h00, 8'h00, 1'b0, 1'b0, "R11 fourth byte");
    bus_stop();
    check("R11 long cancelled", {6'd0, wr_mask_o}, 8'h02);
    prot_cmd(CLR_R, 1'b1, "R7 clear");
    check("R7 low open", {6'd0, wr_mask_o}, 8'h03);
    bus_start();
    send(2'b00, QRY_R, 8'h00, 1'b1, 1'b0, "R7 query after clear");
    bus_stop();
  endtask

  task automatic t_permanent();
    hv_i = 1'b0;
    prot_cmd(SET_P, 1'b1, "R8 set");
    check("R8 low locked", {6'd0, wr_mask_o}, 8'h02);
    bus_start();
    send(2'b00, QRY_P, 8'h00, 1'b0, 1'b0, "R10 query p set");
    bus_stop();
    hv_i = 1'b1;
    prot_cmd(CLR_R, 1'b0, "R8 clear refused");
    bus_start();
    send(2'b00, QRY_R, 8'h00, 1'b0, 1'b0, "R8 query refused");
    bus_stop();
    hv_i = 1'b0;
    bus_start();
    bus_stop();
    check("R8 survives start stop", {6'd0, wr_mask_o}, 8'h02);
    bus_start();
    send(2'b00, MEM_WR, 8'h00, 1'b1, 1'b0, "R8 dev");
    send(2'b01, 8'h00, 8'h00, 1'b1, 1'b0, "R8 addr");
    send(2'b10, 8'h77, 8'h05, 1'b0, 1'b0, "R8 low refused");
    send(2'b10, 8'h88, 8'hF0, 1'b1, 1'b1, "R8 high open");
    bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_memory();
    t_wp();
    t_partial();
    t_reversible();
    t_permanent();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule